// File: doc/BRIEF.md
# Banked GPIO Controller with Interrupt Sensing

This block is a memory-mapped general-purpose I/O controller organised as a row of identical banks. Each bank owns a group of pins. For every pin it holds an output value, a claim bit that gates data access, a direction bit and an input-enable bit. It also holds an interrupt detector. Three independent configuration bits set how the detector senses: level or edge, both edges, and polarity. Software reaches every register over a flat 32-bit register bus. A bus address selects a bank through its upper bits and a register through its lower bits.

Pad inputs are first gated by the pin's input-enable bit. They then pass through a two-flop synchronizer before anything reads them or detects events on them. Edge events are latched until software writes a one to the matching clear bit. Level sensing follows the synchronized input directly. A per-bank masked status is the raw status qualified by the interrupt enables. The masked bits of all banks are ORed into a single interrupt line.

The design has no sequencing state machine. It is built from registers, a synchronizer and edge comparators. The only stateful behaviours are the synchronizer pipeline and the per-pin latched edge status.

Top module: `gpiox_ctrl`

## Requirements
- R1: After reset every register reads 0, `pad_oe_o` is all zero and `irq_o` is 0. Every pin is then an unclaimed input with interrupts disabled, set to falling-edge sensing.
- R2: Address decoding works as follows:
  - `addr_i[ADDR_W-1:7]` selects the bank, `addr_i[6:2]` selects the register, and `addr_i[1:0]` is ignored.
  - Registers sit at these byte offsets: 0x00 data, 0x04 claim, 0x08 direction, 0x0C level-select, 0x10 both-edges, 0x14 polarity, 0x18 interrupt enable, 0x1C raw status, 0x20 masked status, 0x24 clear, 0x28 input enable.
  - Only bits 15:0 are used, and upper read bits are 0.
  - The clear register and the offsets 0x2C to 0x7C read 0.
  - Writes to raw status, masked status and unused offsets change nothing.
- R3: `pad_oe_o` for a pin equals its direction bit, where 1 means output. `pad_out_o` for a pin equals its stored data bit.
- R4: A data write changes only the pins whose claim bit is 1. A pin with a claim bit of 0 reads back 0 at offset 0x00.
- R5: For a claimed pin, a data read returns the stored data bit when the direction bit is 1. When the direction bit is 0 it returns the synchronized input.
- R6: A pin whose input-enable bit is 0 is seen as a constant low by both data reads and the detector.
- R7: In edge mode (level-select 0) with both-edges 0, a polarity of 1 latches raw status on a rising edge of the synchronized input and a polarity of 0 latches it on a falling edge. The opposite edge does not set it.
- R8: In edge mode with both-edges 1, either edge latches raw status, whatever the polarity bit holds.
- R9: In level mode (level-select 1), raw status equals the synchronized input when polarity is 1 and its inverse when polarity is 0. Writing clear has no effect on it.
- R10: Masked status equals raw status ANDed with the interrupt-enable bits. `irq_o` is the OR of all masked status bits of all banks.
- R11: Writing 1 to a clear bit resets that pin's latched edge status. Bits written as 0 are left unchanged.
- R12: A pad change is read back at offset 0x00 after the second rising clock edge. A resulting edge shows in raw status after the third rising clock edge, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| addr_i | input | ADDR_W (11) | Byte address: bank index above bit 7, register word in bits 6:2 |
| wr_en_i | input | 1 | Write strobe for the addressed register |
| wr_data_i | input | 32 | Write data, bits 15:0 used |
| rd_data_o | output | 32 | Combinational read data of the addressed register |
| pad_in_i | input | NUM_BANKS*PINS_PER_BANK | Pad input levels |
| pad_out_o | output | NUM_BANKS*PINS_PER_BANK | Pad output values |
| pad_oe_o | output | NUM_BANKS*PINS_PER_BANK | Pad output enables |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench builds the controller with its default sizing of 16 banks of 16 pins. This makes the highest bank index and the full 11-bit address decode reachable, and random accesses spread across every bank. Random register writes, pad changes and reads run against a register-level model. Directed cases cover the synchronizer latency, each sense mode, claim gating and input-enable gating.

// File: rtl/gpiox_pkg.sv
package gpiox_pkg;

    localparam int REG_SEL_W  = 5;
    localparam int BANK_LSB   = 7;
    localparam int BUS_W      = 32;

    typedef enum logic [REG_SEL_W-1:0] {
        SEL_DATA  = 5'd0,
        SEL_CLAIM = 5'd1,
        SEL_DIR   = 5'd2,
        SEL_LEVEL = 5'd3,
        SEL_BOTH  = 5'd4,
        SEL_POL   = 5'd5,
        SEL_IEN   = 5'd6,
        SEL_RAW   = 5'd7,
        SEL_MSTAT = 5'd8,
        SEL_CLR   = 5'd9,
        SEL_INEN  = 5'd10
    } reg_sel_e;

endpackage

// File: rtl/gpiox_sync.sv
module gpiox_sync #(
    parameter int W = 16
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] safe_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            meta_q <= '0;
            safe_q <= '0;
        end else begin
            meta_q <= d_i;
            safe_q <= meta_q;
        end
    end

    assign q_o = safe_q;
endmodule

// File: rtl/gpiox_edge.sv
module gpiox_edge #(
    parameter int W = 16
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [W-1:0] in_i,
    input  logic [W-1:0] level_i,
    input  logic [W-1:0] both_i,
    input  logic [W-1:0] pol_i,
    output logic [W-1:0] evt_o,
    output logic [W-1:0] lvl_o
);
    logic [W-1:0] prev_q;
    logic [W-1:0] rise;
    logic [W-1:0] fall;

    always_ff @(posedge clk_i) begin
        if (rst_i) prev_q <= '0;
        else       prev_q <= in_i;
    end

    assign rise = in_i & ~prev_q;
    assign fall = prev_q & ~in_i;

    for (genvar g = 0; g < W; g++) begin : g_pin
        always_comb begin
            if (level_i[g])     evt_o[g] = 1'b0;
            else if (both_i[g]) evt_o[g] = rise[g] | fall[g];
            else if (pol_i[g])  evt_o[g] = rise[g];
            else                evt_o[g] = fall[g];
        end
        assign lvl_o[g] = pol_i[g] ? in_i[g] : ~in_i[g];
    end
endmodule

// File: rtl/gpiox_bank.sv
module gpiox_bank
    import gpiox_pkg::*;
#(
    parameter int PINS = 16
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic            we_i,
    input  reg_sel_e        sel_i,
    input  logic [PINS-1:0] wdata_i,
    input  logic [PINS-1:0] pad_i,
    output logic [PINS-1:0] pad_out_o,
    output logic [PINS-1:0] pad_oe_o,
    output logic [PINS-1:0] rdata_o,
    output logic            irq_o
);
    logic [PINS-1:0] data_q, claim_q, dir_q, level_q, both_q, pol_q, ien_q, inen_q;
    logic [PINS-1:0] hold_q;
    logic [PINS-1:0] gated, synced, evt, lvl, raw, mstat, clr_bits;

    assign gated = pad_i & inen_q;

    gpiox_sync #(.W(PINS)) u_sync (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   (gated),
        .q_o   (synced)
    );

    gpiox_edge #(.W(PINS)) u_edge (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .in_i    (synced),
        .level_i (level_q),
        .both_i  (both_q),
        .pol_i   (pol_q),
        .evt_o   (evt),
        .lvl_o   (lvl)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            data_q  <= '0;
            claim_q <= '0;
            dir_q   <= '0;
            level_q <= '0;
            both_q  <= '0;
            pol_q   <= '0;
            ien_q   <= '0;
            inen_q  <= '0;
        end else if (we_i) begin
            case (sel_i)
                SEL_DATA:  data_q  <= (data_q & ~claim_q) | (wdata_i & claim_q);
                SEL_CLAIM: claim_q <= wdata_i;
                SEL_DIR:   dir_q   <= wdata_i;
                SEL_LEVEL: level_q <= wdata_i;
                SEL_BOTH:  both_q  <= wdata_i;
                SEL_POL:   pol_q   <= wdata_i;
                SEL_IEN:   ien_q   <= wdata_i;
                SEL_INEN:  inen_q  <= wdata_i;
                default:   ;
            endcase
        end
    end

    assign clr_bits = (we_i && sel_i == SEL_CLR) ? wdata_i : '0;

    always_ff @(posedge clk_i) begin
        if (rst_i) hold_q <= '0;
        else       hold_q <= (hold_q & ~clr_bits) | evt;
    end

    assign raw   = (level_q & lvl) | (~level_q & hold_q);
    assign mstat = raw & ien_q;
    assign irq_o = |mstat;

    assign pad_out_o = data_q;
    assign pad_oe_o  = dir_q;

    always_comb begin
        case (sel_i)
            SEL_DATA:  rdata_o = claim_q & ((dir_q & data_q) | (~dir_q & synced));
            SEL_CLAIM: rdata_o = claim_q;
            SEL_DIR:   rdata_o = dir_q;
            SEL_LEVEL: rdata_o = level_q;
            SEL_BOTH:  rdata_o = both_q;
            SEL_POL:   rdata_o = pol_q;
            SEL_IEN:   rdata_o = ien_q;
            SEL_RAW:   rdata_o = raw;
            SEL_MSTAT: rdata_o = mstat;
            SEL_INEN:  rdata_o = inen_q;
            default:   rdata_o = '0;
        endcase
    end

    // R4
    unclaimed_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        1'b1 |=> (((data_q ^ $past(data_q)) & ~$past(claim_q)) == '0));

    // R3
    oe_stable_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !(we_i && sel_i == SEL_DIR) |=> $stable(pad_oe_o));

    // R7
    latch_cause_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        1'b1 |=> ((hold_q & ~$past(hold_q) & ~$past(evt)) == '0));

    // R11
    clear_effect_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (we_i && sel_i == SEL_CLR) |=> ((hold_q & $past(wdata_i & ~evt)) == '0));
endmodule

// File: rtl/gpiox_ctrl.sv
module gpiox_ctrl
    import gpiox_pkg::*;
#(
    parameter int NUM_BANKS     = 16,
    parameter int PINS_PER_BANK = 16,
    localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int ADDR_W = BANK_LSB + BANK_W,
    localparam int NPINS  = NUM_BANKS * PINS_PER_BANK
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic [BUS_W-1:0]  wr_data_i,
    output logic [BUS_W-1:0]  rd_data_o,
    input  logic [NPINS-1:0]  pad_in_i,
    output logic [NPINS-1:0]  pad_out_o,
    output logic [NPINS-1:0]  pad_oe_o,
    output logic              irq_o
);
    logic [BANK_W-1:0]        bank_idx;
    reg_sel_e                 sel;
    logic [NUM_BANKS-1:0]     bank_we;
    logic [NUM_BANKS-1:0]     bank_irq;
    logic [PINS_PER_BANK-1:0] bank_rd [NUM_BANKS];

    assign bank_idx = addr_i[ADDR_W-1:BANK_LSB];
    assign sel      = reg_sel_e'(addr_i[BANK_LSB-1:2]);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign bank_we[b] = wr_en_i && (int'(bank_idx) == b);

        gpiox_bank #(.PINS(PINS_PER_BANK)) u_bank (
            .clk_i     (clk_i),
            .rst_i     (rst_i),
            .we_i      (bank_we[b]),
            .sel_i     (sel),
            .wdata_i   (wr_data_i[PINS_PER_BANK-1:0]),
            .pad_i     (pad_in_i[b*PINS_PER_BANK +: PINS_PER_BANK]),
            .pad_out_o (pad_out_o[b*PINS_PER_BANK +: PINS_PER_BANK]),
            .pad_oe_o  (pad_oe_o[b*PINS_PER_BANK +: PINS_PER_BANK]),
            .rdata_o   (bank_rd[b]),
            .irq_o     (bank_irq[b])
        );
    end

    always_comb begin
        rd_data_o = '0;
        for (int i = 0; i < NUM_BANKS; i++) begin
            if (int'(bank_idx) == i) rd_data_o[PINS_PER_BANK-1:0] = bank_rd[i];
        end
    end

    assign irq_o = |bank_irq;

    // R1
    reset_quiet_chk: assert property (@(posedge clk_i)
        $past(rst_i) |-> (!irq_o && pad_oe_o == '0));

    // R2
    unused_offset_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (addr_i[BANK_LSB-1:2] > 5'd10 || addr_i[BANK_LSB-1:2] == 5'd9) |-> (rd_data_o == '0));
endmodule

// File: tb/gpiox_ctrl_test.sv
module gpiox_ctrl_test;
    localparam int NB = 16;
    localparam int PW = 16;
    localparam int NP = NB * PW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [10:0]   addr = '0;
    logic          wr_en = 1'b0;
    logic [31:0]   wr_data = '0;
    logic [31:0]   rd_data;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] pad_out, pad_oe;
    logic          irq;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [15:0] m_data [NB], m_claim [NB], m_dir [NB], m_lvl [NB], m_both [NB];
    logic [15:0] m_pol [NB], m_ien [NB], m_inen [NB], m_hold [NB];
    logic [NP-1:0] pin = '0;

    always #5 clk = ~clk;

    gpiox_ctrl uut (
        .clk_i(clk), .rst_i(rst), .addr_i(addr), .wr_en_i(wr_en), .wr_data_i(wr_data),
        .rd_data_o(rd_data), .pad_in_i(pad_in), .pad_out_o(pad_out), .pad_oe_o(pad_oe),
        .irq_o(irq)
    );

    function automatic logic [15:0] eff(int b);
        return pin[b*PW +: PW] & m_inen[b];
    endfunction

    function automatic logic [15:0] exp_raw(int b);
        logic [15:0] e = eff(b);
        return (m_lvl[b] & ((m_pol[b] & e) | (~m_pol[b] & ~e))) | (~m_lvl[b] & m_hold[b]);
    endfunction

    function automatic logic [31:0] exp_read(int b, int off);
        logic [15:0] v;
        case (off)
            'h00: v = m_claim[b] & ((m_dir[b] & m_data[b]) | (~m_dir[b] & eff(b)));
            'h04: v = m_claim[b];
            'h08: v = m_dir[b];
            'h0C: v = m_lvl[b];
            'h10: v = m_both[b];
            'h14: v = m_pol[b];
            'h18: v = m_ien[b];
            'h1C: v = exp_raw(b);
            'h20: v = exp_raw(b) & m_ien[b];
            'h28: v = m_inen[b];
            default: v = '0;
        endcase
        return {16'h0, v};
    endfunction

    function automatic logic exp_irq();
        logic r = 1'b0;
        for (int b = 0; b < NB; b++) r |= |(exp_raw(b) & m_ien[b]);
        return r;
    endfunction

    function automatic void apply_edges(int b, logic [15:0] old_e, logic [15:0] new_e);
        logic [15:0] rise = new_e & ~old_e;
        logic [15:0] fall = old_e & ~new_e;
        logic [15:0] sel  = (m_both[b] & (rise | fall)) |
                            (~m_both[b] & ((m_pol[b] & rise) | (~m_pol[b] & fall)));
        m_hold[b] |= ~m_lvl[b] & sel;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(int b, int off, logic [31:0] d);
        logic [15:0] old_e;
        @(negedge clk);
        addr = {b[3:0], off[6:0]};
        wr_data = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        case (off)
            'h00: m_data[b] = (m_data[b] & ~m_claim[b]) | (d[15:0] & m_claim[b]);
            'h04: m_claim[b] = d[15:0];
            'h08: m_dir[b] = d[15:0];
            'h0C: m_lvl[b] = d[15:0];
            'h10: m_both[b] = d[15:0];
            'h14: m_pol[b] = d[15:0];
            'h18: m_ien[b] = d[15:0];
            'h24: m_hold[b] &= ~d[15:0];
            'h28: begin
                old_e = eff(b);
                m_inen[b] = d[15:0];
                apply_edges(b, old_e, eff(b));
            end
            default: ;
        endcase
        idle(4);
    endtask

    task automatic set_pads(int b, logic [15:0] v);
        logic [15:0] old_e;
        @(negedge clk);
        old_e = eff(b);
        pin[b*PW +: PW] = v;
        pad_in = pin;
        apply_edges(b, old_e, eff(b));
        idle(4);
    endtask

    task automatic read_chk(int b, int off, string tag);
        @(negedge clk);
        addr = {b[3:0], off[6:0]};
        #1;
        chk(tag, rd_data, exp_read(b, off));
    endtask

    task automatic irq_chk(string tag);
        #1;
        chk(tag, {31'h0, irq}, {31'h0, exp_irq()});
    endtask

    function automatic string tag_of(int off);
        case (off)
            'h00: return "R5";
            'h08: return "R3";
            'h1C: return "R7";
            'h20: return "R10";
            default: return "R2";
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int b = 0; b < NB; b++) begin
            m_data[b] = '0; m_claim[b] = '0; m_dir[b] = '0; m_lvl[b] = '0; m_both[b] = '0;
            m_pol[b] = '0; m_ien[b] = '0; m_inen[b] = '0; m_hold[b] = '0;
        end
        idle(3);
        rst = 1'b0;
        idle(2);

        // R1 reset state
        for (int k = 0; k < 12; k++) read_chk(0, k * 4, "R1");
        for (int k = 0; k < 12; k++) read_chk(NB - 1, k * 4, "R1");
        chk("R1", pad_oe, '0);
        irq_chk("R1");

        // R3 / R5 output direction and readback
        bus_write(2, 'h04, 32'hFFFF);
        bus_write(2, 'h08, 32'h00F0);
        bus_write(2, 'h00, 32'h5A5A);
        chk("R3", {16'h0, pad_oe[2*PW +: PW]}, 32'h00F0);
        chk("R3", {16'h0, pad_out[2*PW +: PW]}, 32'h5A5A);
        read_chk(2, 'h00, "R5");
        chk("R5", rd_data, 32'h0050);

        // R4 claim gating
        bus_write(3, 'h04, 32'h00FF);
        bus_write(3, 'h08, 32'hFFFF);
        bus_write(3, 'h00, 32'hFFFF);
        read_chk(3, 'h00, "R4");
        chk("R4", rd_data, 32'h00FF);
        bus_write(3, 'h04, 32'hFFFF);
        read_chk(3, 'h00, "R4");
        chk("R4", {16'h0, pad_out[3*PW +: PW]}, 32'h00FF);

        // R6 input enable gating
        bus_write(4, 'h04, 32'hFFFF);
        set_pads(4, 16'hA5C3);
        read_chk(4, 'h00, "R6");
        chk("R6", rd_data, 32'h0000);
        bus_write(4, 'h28, 32'hFFFF);
        read_chk(4, 'h00, "R6");
        chk("R6", rd_data, 32'hA5C3);

        // R12 synchronizer latency
        bus_write(5, 'h04, 32'hFFFF);
        bus_write(5, 'h28, 32'hFFFF);
        bus_write(5, 'h14, 32'hFFFF);
        @(negedge clk);
        addr = {4'd5, 7'h1C};
        pad_in[5*PW] = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk); #1;
        chk("R12", rd_data, 32'h0000);
        @(posedge clk); @(negedge clk); #1;
        chk("R12", rd_data, 32'h0001);
        addr = {4'd5, 7'h00};
        pad_in[5*PW + 1] = 1'b1;
        @(posedge clk); @(negedge clk); #1;
        chk("R12", rd_data, 32'h0001);
        @(posedge clk); @(negedge clk); #1;
        chk("R12", rd_data, 32'h0003);
        pin[5*PW +: PW] = 16'h0003;
        m_hold[5] = 16'h0003;
        idle(4);
        read_chk(5, 'h1C, "R12");

        // R7 falling-only, then R8 both edges
        bus_write(6, 'h28, 32'hFFFF);
        set_pads(6, 16'h0001);
        read_chk(6, 'h1C, "R7");
        chk("R7", rd_data, 32'h0000);
        set_pads(6, 16'h0000);
        read_chk(6, 'h1C, "R7");
        chk("R7", rd_data, 32'h0001);
        bus_write(6, 'h24, 32'h0001);
        // R11 cleared
        read_chk(6, 'h1C, "R11");
        chk("R11", rd_data, 32'h0000);
        bus_write(6, 'h10, 32'h0002);
        set_pads(6, 16'h0002);
        read_chk(6, 'h1C, "R8");
        chk("R8", rd_data, 32'h0002);

        // R9 level mode, R10 masking and irq
        bus_write(7, 'h28, 32'hFFFF);
        bus_write(7, 'h0C, 32'h0010);
        bus_write(7, 'h14, 32'h0010);
        set_pads(7, 16'h0010);
        read_chk(7, 'h1C, "R9");
        chk("R9", rd_data & 32'h0010, 32'h0010);
        bus_write(7, 'h24, 32'hFFFF);
        read_chk(7, 'h1C, "R9");
        chk("R9", rd_data & 32'h0010, 32'h0010);
        irq_chk("R10");
        bus_write(7, 'h18, 32'h0010);
        read_chk(7, 'h20, "R10");
        irq_chk("R10");
        chk("R10", {31'h0, irq}, 32'h1);
        set_pads(7, 16'h0000);
        read_chk(7, 'h1C, "R9");
        irq_chk("R10");

        // R2 read-only / unused offsets
        bus_write(6, 'h1C, 32'hFFFF_FFFF);
        bus_write(6, 'h20, 32'hFFFF_FFFF);
        bus_write(6, 'h3C, 32'hFFFF_FFFF);
        read_chk(6, 'h1C, "R2");
        read_chk(6, 'h24, "R2");
        read_chk(6, 'h3C, "R2");
        read_chk(6, 'h7C, "R2");
        bus_write(8, 'h04, 32'hFFFF_FFFF);
        read_chk(8, 'h04, "R2");
        chk("R2", rd_data, 32'h0000_FFFF);

        // random mix
        for (int it = 0; it < 400; it++) begin
            int b = int'($urandom % NB);
            int sel = int'($urandom % 10);
            if (sel < 4) begin
                bus_write(b, int'($urandom % 12) * 4, $urandom);
                chk("R3", {16'h0, pad_oe[b*PW +: PW]}, {16'h0, m_dir[b]});
                chk("R3", {16'h0, pad_out[b*PW +: PW]}, {16'h0, m_data[b]});
            end else if (sel < 7) begin
                set_pads(b, 16'($urandom));
            end else begin
                int off = int'($urandom % 16) * 4;
                read_chk(b, off, tag_of(off));
            end
            irq_chk("R10");
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule